// File: doc/BRIEF.md
# Programmable dot clock post-divider

This block takes a fast clock from a PLL and divides it down to a pixel-rate clock. It produces two things: a clock-shaped output, and a one-cycle strobe that downstream logic can use as a clock enable. The division ratio is not set directly. A code register holds four independent 2-bit ratio codes, one per selectable setting. A select register chooses which of the four settings drives the divider. An extension register holds one extra bit per setting. When that bit is set, the setting uses the non-power-of-two ratios 3, 5, 6 and 12. When it is clear, the setting uses 1, 2, 4 and 8.

When every extension bit is zero, the block behaves exactly like a divider that only has the power-of-two ratios. Ratio changes are deferred until the running output period has finished, so switching never produces a shortened or stretched pulse. Software reaches all three registers through a small synchronous write port and a combinational read port.

Top module: `dotclk_postdiv`

## Requirements
- R1: The code register sits at address 0 and holds four 2-bit fields. Field n occupies bits [2n+1:2n]. A write stores all 8 bits, and a read returns them unchanged.
- R2: The select register sits at address 2. Its bits [1:0] name the active field. All 8 written bits read back, and bits [7:2] have no effect on the ratio.
- R3: The extension register sits at address 1. Bit 4+n is the extension bit of field n. All 8 written bits read back, and bits [3:0] have no effect on the ratio.
- R4: With the active field's extension bit clear, codes 0, 1, 2 and 3 divide by 1, 2, 4 and 8.
- R5: With the active field's extension bit set, codes 0, 1, 2 and 3 divide by 3, 5, 6 and 12.
- R6: A change of ratio, whether from a register write or a new selection, takes effect only after the period in progress has completed at the old ratio.
- R7: Each output period starts with the clock output high. The high phase lasts N/2 input cycles for even N and floor(N/2) cycles for odd N greater than 1. At N = 1 the output stays high.
- R8: The strobe is high for exactly one input cycle per output period, on the last input cycle of that period.
- R9: Synchronous active-low reset clears all registers, which gives divide by 1. Address 3 reads as zero, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock from the PLL |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write enable for the register port |
| reg_addr | input | 2 | Register address: 0 code, 1 extension, 2 select |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for reg_addr (combinational) |
| clk_out | output | 1 | Divided clock output, registered |
| tick | output | 1 | One-cycle strobe on the last input cycle of each period |

## Verification
The bench builds the block with its default four fields and 8-bit registers. This size is small enough to sweep every combination of field, extension bit and code, which is all 32 ratio settings.

For each setting, the unused fields and the unused extension bits are loaded with opposite values. The idle register bits are loaded with junk. A wrong bit position or a leak from one of those bits would then change the measured period or high time.

The deferred-switch case is driven directly: the ratio is rewritten in the middle of a divide-by-12 period, and the bench checks that this period still runs to its full length.

// File: rtl/dotclk_pkg.sv
// Package: dotclk_pkg
// Shared widths and the ratio decode for the dot clock post-divider.
// Assumes 2-bit ratio codes and a largest ratio of 12, so 4 bits are enough for a ratio.
package dotclk_pkg;
    localparam int CODE_W  = 2;
    localparam int RATIO_W = 4;

    typedef logic [RATIO_W-1:0] ratio_t;

    // Map an extension bit and a code to a division ratio.
    function automatic ratio_t ratio_of(input logic ext, input logic [CODE_W-1:0] code);
        unique case ({ext, code})
            3'b000:  return ratio_t'(1);
            3'b001:  return ratio_t'(2);
            3'b010:  return ratio_t'(4);
            3'b011:  return ratio_t'(8);
            3'b100:  return ratio_t'(3);
            3'b101:  return ratio_t'(5);
            3'b110:  return ratio_t'(6);
            default: return ratio_t'(12);
        endcase
    endfunction
endpackage

// File: rtl/dcd_regfile.sv
// Module: dcd_regfile
// Holds the code, extension and select registers and drives the combinational read data.
// Assumes reg_wdata is REG_W bits wide and that the extension bits are the top FIELDS bits.
// Unmapped address 3 reads as zero and ignores writes.
module dcd_regfile #(
    parameter int FIELDS = 4,
    parameter int REG_W  = 8,
    localparam int SEL_W = $clog2(FIELDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic [REG_W-1:0] code_q,
    output logic [FIELDS-1:0] ext_bits,
    output logic [SEL_W-1:0] sel_bits
);
    logic [REG_W-1:0] ext_q;
    logic [REG_W-1:0] sel_q;

    // Register writes, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            ext_q  <= '0;
            sel_q  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                2'd0:    code_q <= reg_wdata;
                2'd1:    ext_q  <= reg_wdata;
                2'd2:    sel_q  <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Combinational readback of the full stored values.
    always_comb begin
        case (reg_addr)
            2'd0:    reg_rdata = code_q;
            2'd1:    reg_rdata = ext_q;
            2'd2:    reg_rdata = sel_q;
            default: reg_rdata = '0;
        endcase
    end

    assign ext_bits = ext_q[REG_W-1 -: FIELDS];
    assign sel_bits = sel_q[SEL_W-1:0];
endmodule

// File: rtl/dcd_ratio_select.sv
// Module: dcd_ratio_select
// Decodes one ratio per field and picks the ratio of the selected field.
// Assumes field n of the code register occupies bits [2n+1:2n].
module dcd_ratio_select
    import dotclk_pkg::*;
#(
    parameter int FIELDS = 4,
    parameter int REG_W  = 8,
    localparam int SEL_W = $clog2(FIELDS)
) (
    input  logic [REG_W-1:0]  code_q,
    input  logic [FIELDS-1:0] ext_bits,
    input  logic [SEL_W-1:0]  sel_bits,
    output ratio_t            target_n
);
    ratio_t ratio_arr [FIELDS];

    // One decoder per field.
    for (genvar g = 0; g < FIELDS; g++) begin : g_field
        assign ratio_arr[g] = ratio_of(ext_bits[g], code_q[CODE_W*g +: CODE_W]);
    end

    assign target_n = ratio_arr[sel_bits];
endmodule

// File: rtl/dcd_period_gen.sv
// Module: dcd_period_gen
// Counts input cycles within each output period.
// It loads a new ratio only at a period boundary and registers both the clock output and the strobe.
// Assumes target_n is 1 or greater.
module dcd_period_gen
    import dotclk_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  ratio_t target_n,
    output logic   clk_out,
    output logic   tick,
    output ratio_t cnt,
    output ratio_t cur_n
);
    ratio_t cnt_nxt;
    ratio_t n_nxt;
    ratio_t hi_len;

    // Next-state: wrap and load the new ratio on the final cycle of a period.
    always_comb begin
        if (tick) begin
            cnt_nxt = '0;
            n_nxt   = target_n;
        end else begin
            cnt_nxt = cnt + ratio_t'(1);
            n_nxt   = cur_n;
        end
        hi_len = (n_nxt == ratio_t'(1)) ? ratio_t'(1) : (n_nxt >> 1);
    end

    // State and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            cur_n   <= ratio_t'(1);
            clk_out <= 1'b1;
            tick    <= 1'b1;
        end else begin
            cnt     <= cnt_nxt;
            cur_n   <= n_nxt;
            clk_out <= (cnt_nxt < hi_len);
            tick    <= (cnt_nxt == n_nxt - ratio_t'(1));
        end
    end
endmodule

// File: rtl/dotclk_postdiv.sv
// Module: dotclk_postdiv
// Top of the dot clock post-divider.
// Wires the register file, the ratio selection and the period generator together.
// Assumes a single clock domain and a synchronous active-low reset.
module dotclk_postdiv
    import dotclk_pkg::*;
#(
    parameter int FIELDS = 4,
    parameter int REG_W  = 8,
    localparam int SEL_W = $clog2(FIELDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             clk_out,
    output logic             tick
);
    logic [REG_W-1:0]  code_q;
    logic [FIELDS-1:0] ext_bits;
    logic [SEL_W-1:0]  sel_bits;
    ratio_t            target_n;
    ratio_t            cnt;
    ratio_t            cur_n;

    dcd_regfile #(.FIELDS(FIELDS), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .code_q(code_q),
        .ext_bits(ext_bits), .sel_bits(sel_bits)
    );

    dcd_ratio_select #(.FIELDS(FIELDS), .REG_W(REG_W)) u_sel (
        .code_q(code_q), .ext_bits(ext_bits), .sel_bits(sel_bits), .target_n(target_n)
    );

    dcd_period_gen u_gen (
        .clk(clk), .rst_n(rst_n), .target_n(target_n), .clk_out(clk_out),
        .tick(tick), .cnt(cnt), .cur_n(cur_n)
    );
endmodule

// File: rtl/dotclk_postdiv_chk.sv
// Module: dotclk_postdiv_chk
// Assertion checker bound to dotclk_postdiv.
// Observes the ports, the code register and the period state.
module dotclk_postdiv_chk
    import dotclk_pkg::*;
#(
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] code_q,
    input logic             tick,
    input logic             clk_out,
    input ratio_t           cnt,
    input ratio_t           cur_n
);
    // R1: a code write is stored in full.
    a_r1_code_store: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0) |=> (code_q == $past(reg_wdata)));

    // R4 / R5: the active ratio is always one of the legal values.
    a_r4_ratio_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cur_n inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd8, 4'd12});

    // R6: the ratio holds for the whole period.
    a_r6_ratio_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cur_n));

    // R7: every period begins with the output high.
    a_r7_high_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> clk_out);

    // R8: the strobe closes the period and the count restarts.
    a_r8_tick_restart: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == 4'd0));

    // R8: the count stays within the period.
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < cur_n);
endmodule

bind dotclk_postdiv dotclk_postdiv_chk #(.REG_W(REG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .code_q(code_q), .tick(tick), .clk_out(clk_out),
    .cnt(cnt), .cur_n(cur_n)
);

// File: tb/dotclk_postdiv_test.sv
`timescale 1ns/1ps
// Bench for dotclk_postdiv.
// Sweeps every field, extension bit and code, and measures period and high time at the ports.
module dotclk_postdiv_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       clk_out;
    logic       tick;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    dotclk_postdiv uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_out(clk_out), .tick(tick)
    );

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        reg_addr = a;
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic sync_tick();
        int g = 0;
        while (!tick && g < 100) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic measure(output int per, output int hi);
        per = 0; hi = 0;
        do begin
            @(negedge clk);
            per++;
            if (clk_out) hi++;
        end while (!tick && per < 100);
    endtask

    function automatic int exp_ratio(input int e, input int c);
        int t[4] = '{3, 5, 6, 12};
        return (e != 0) ? t[c] : (1 << c);
    endfunction

    function automatic int exp_hi(input int n);
        return (n == 1) ? 1 : n / 2;
    endfunction

    initial begin
        int v, per, hi;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state.
        rd(2'd0, v); chk("R9", "code after reset", v, 0);
        rd(2'd1, v); chk("R9", "ext after reset", v, 0);
        rd(2'd2, v); chk("R9", "sel after reset", v, 0);
        chk("R9", "tick after reset", int'(tick), 1);
        chk("R7", "clk_out after reset", int'(clk_out), 1);
        measure(per, hi);
        chk("R9", "period after reset", per, 1);
        chk("R7", "high at N=1", hi, 1);

        // R9: address 3 reads zero and its writes are ignored.
        wr(2'd3, 8'hFF);
        rd(2'd3, v); chk("R9", "addr3 read", v, 0);
        rd(2'd0, v); chk("R9", "code after addr3 write", v, 0);
        rd(2'd1, v); chk("R9", "ext after addr3 write", v, 0);
        rd(2'd2, v); chk("R9", "sel after addr3 write", v, 0);
        sync_tick();
        measure(per, hi); chk("R9", "period after addr3 write", per, 1);

        // R1..R5, R7, R8: sweep every field, extension bit and code.
        for (int f = 0; f < 4; f++) begin
            for (int e = 0; e < 2; e++) begin
                for (int c = 0; c < 4; c++) begin
                    logic [7:0] code_v, ext_v, sel_v;
                    int n;
                    code_v = '0;
                    for (int k = 0; k < 4; k++)
                        code_v[2*k +: 2] = (k == f) ? 2'(c) : ~2'(c);
                    ext_v = (e != 0) ? (8'h10 << f) : (8'hF0 & ~(8'h10 << f));
                    ext_v = ext_v | 8'h0A;
                    sel_v = 8'(f) | 8'hA8;
                    wr(2'd0, code_v);
                    wr(2'd1, ext_v);
                    wr(2'd2, sel_v);
                    rd(2'd0, v); chk("R1", "code readback", v, int'(code_v));
                    rd(2'd1, v); chk("R3", "ext readback", v, int'(ext_v));
                    rd(2'd2, v); chk("R2", "sel readback", v, int'(sel_v));
                    n = exp_ratio(e, c);
                    sync_tick();
                    for (int p = 0; p < 2; p++) begin
                        measure(per, hi);
                        chk((e != 0) ? "R5" : "R4", "period", per, n);
                        chk("R7", "high time", hi, exp_hi(n));
                    end
                    chk("R8", "tick on last cycle", int'(tick), 1);
                end
            end
        end

        // R6: a rewrite in mid-period does not cut the period short.
        wr(2'd0, 8'h03);
        wr(2'd1, 8'h10);
        wr(2'd2, 8'h00);
        sync_tick();
        measure(per, hi); chk("R6", "setup period", per, 12);
        per = 0;
        repeat (3) begin
            @(negedge clk);
            per++;
        end
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h00;
        @(negedge clk);
        per++;
        reg_wr = 1'b0;
        while (!tick && per < 100) begin
            @(negedge clk);
            per++;
        end
        chk("R6", "period in progress keeps old ratio", per, 12);
        measure(per, hi); chk("R6", "next period uses new ratio", per, 3);
        chk("R7", "high time at N=3", hi, 1);

        // R6: a new selection also waits for the period boundary.
        wr(2'd0, 8'h0F);
        wr(2'd1, 8'h00);
        sync_tick();
        measure(per, hi); chk("R6", "field0 period", per, 8);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h02;
        @(negedge clk);
        reg_wr = 1'b0;
        per = 2;
        while (!tick && per < 100) begin
            @(negedge clk);
            per++;
        end
        chk("R6", "select change waits for boundary", per, 8);
        measure(per, hi); chk("R6", "field2 period", per, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule